// File: doc/BRIEF.md
# Dual-Sided Interprocessor Mailbox

This block joins two processors, called side A and side B, each of which sees its own small register window on a plain synchronous bus port. There are four 32-bit message slots in each direction. A word written into one of a side's transmit slots appears in the receive slot with the same index on the opposite side. Reading that receive slot frees the transmit slot again. Messages longer than four words are streamed through slot (i mod 4). The sender waits for the transmit-empty bit of that slot before writing it again, and the receiver waits for the receive-full bit before reading.

Four doorbells run in each direction beside the data slots. A side rings doorbell n by writing its control register with the request bit for n set. The peer then sees a pending bit, and acknowledges it by writing 1 to that bit in its status register. Each side has one interrupt output. It is high when any status bit is set together with the control enable bit at the same position.

Each slot is a two-state machine. In SLOT_EMPTY, a push moves it to SLOT_FULL. In SLOT_FULL, a push keeps it in SLOT_FULL with the new data; otherwise a pop moves it back to SLOT_EMPTY. Each doorbell is a two-state machine. In BELL_IDLE, a request moves it to BELL_RING. In BELL_RING, it returns to BELL_IDLE on the acknowledge and ignores further requests.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every transmit-empty bit reads 1 and every receive-full and pending bit reads 0. Status reads 0x00F00200, control reads 0, and both interrupts are low.
- R2: Transmit slot n sits at byte offset 4n and receive slot n at 0x10+4n. With ALT_MAP=0 the status register is at 0x20 and control at 0x24; with ALT_MAP=1 they are at 0x60 and 0x64.
- R3: Writing transmit slot n clears the writer's status bit 20+(3-n) (transmit-empty) and sets the peer's status bit 24+(3-n) (receive-full).
- R4: A read strobe on receive slot n returns the stored word on rdata one cycle later. It clears that receive-full bit and sets the writer's transmit-empty bit again.
- R5: Reading the status register, or reading a receive slot that is empty, changes no status bit on either side.
- R6: Writing control with bit 16+(3-n) set rings doorbell n toward the peer. The peer's status bit 28+(3-n) sets, and the writer's control bit 16+(3-n) reads 1 while the doorbell is ringing.
- R7: Writing 1 to status bit 28+(3-n) clears that pending bit and makes the ringing side's request bit read 0. Writing 0 there leaves the pending bit set.
- R8: Control bits 20+(3-n) (transmit enable), 24+(3-n) (receive enable) and 28+(3-n) (doorbell enable) store the written value and read back. All other control bits that are not request bits read 0.
- R9: A side's interrupt is high exactly when some status bit and the control enable bit at the same position are both 1.
- R10: Status bit 9 is set by reset and indicates that a reset occurred. Writing 1 to bit 9 clears it; writing 0 leaves it set.
- R11: Writing a transmit slot that is already full replaces the word and keeps receive-full set. The peer then reads the latest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | AW | Side A byte address |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data, valid the cycle after the strobe |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | AW | Side B byte address |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data, valid the cycle after the strobe |
| b_irq | output | 1 | Side B interrupt |

## Verification
A write takes effect at the clock edge that samples it. Any status change, interrupt change or doorbell change is therefore visible from the next cycle on, on both sides. Read data is registered and appears one cycle after the read strobe. The bench drives each strobe for a single cycle starting at a falling edge and samples at the following falling edge, one edge after the register that holds the result. Interrupt levels are sampled at a falling edge only after the configuring write has fully completed.

// File: rtl/ipc_mb_pkg.sv
package ipc_mb_pkg;
    typedef enum logic {SLOT_EMPTY, SLOT_FULL} slot_st_t;
    typedef enum logic {BELL_IDLE, BELL_RING} bell_st_t;

    // Field bases; slot n lands at base + (NSLOT-1-n)
    localparam int TE_BASE = 20;
    localparam int RF_BASE = 24;
    localparam int GP_BASE = 28;
    localparam int GR_BASE = 16;
    localparam int RST_BIT = 9;
endpackage

// File: rtl/ipc_mb_slot.sv
module ipc_mb_slot
    import ipc_mb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] data,
    output logic          full
);
    slot_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_EMPTY: if (push) st_d = SLOT_FULL;
            SLOT_FULL:  if (!push && pop) st_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (push) data <= push_data;
    end

    always_comb full = (st_q == SLOT_FULL);

    // R3
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> full && data == $past(push_data));
    // R4
    slot_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push |=> !full);
    // R5
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop && !push |=> $stable(full));
endmodule

// File: rtl/ipc_mb_bell.sv
module ipc_mb_bell
    import ipc_mb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring_req,
    input  logic ack,
    output logic ringing
);
    bell_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BELL_IDLE: if (ring_req) st_d = BELL_RING;
            BELL_RING: if (ack)      st_d = BELL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BELL_IDLE;
        else        st_q <= st_d;
    end

    always_comb ringing = (st_q == BELL_RING);

    // R6
    bell_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_req && !ringing |=> ringing);
    // R7
    bell_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ringing && ack |=> !ringing);
    // R7
    bell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ringing && !ack |=> ringing);
endmodule

// File: rtl/ipc_mb_side.sv
module ipc_mb_side
    import ipc_mb_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 8,
    parameter int NSLOT   = 4,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              addr,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic                       irq,
    output logic [NSLOT-1:0]           tx_push,
    output logic [NSLOT-1:0]           rx_pop,
    output logic [NSLOT-1:0]           gip_ack,
    output logic [NSLOT-1:0]           gir_req,
    input  logic [NSLOT-1:0]           tx_empty,
    input  logic [NSLOT-1:0]           rx_full,
    input  logic [NSLOT-1:0]           gip,
    input  logic [NSLOT-1:0]           gir_state,
    input  logic [NSLOT-1:0][DW-1:0]   rx_data
);
    localparam int WA   = AW - 2;
    localparam int TX_W = 0;
    localparam int RX_W = NSLOT;
    localparam int ST_W = ALT_MAP ? 'h18 : 'h08;
    localparam int CT_W = ST_W + 1;
    localparam logic [DW-1:0] EN_MASK =
        ((DW'(1) << (3 * NSLOT)) - DW'(1)) << TE_BASE;

    logic [WA-1:0] word;
    logic          st_sel, ct_sel;
    logic [DW-1:0] ctrl_en, stat_v, ctrl_v, rd_next;
    logic          rst_flag;
    logic          unused_lsb;

    assign word       = addr[AW-1:2];
    assign unused_lsb = ^addr[1:0];
    assign st_sel     = (word == WA'(ST_W));
    assign ct_sel     = (word == WA'(CT_W));

    for (genvar n = 0; n < NSLOT; n++) begin : g_dec
        assign tx_push[n] = wr_en && word == WA'(TX_W + n);
        assign rx_pop[n]  = rd_en && word == WA'(RX_W + n);
        assign gip_ack[n] = wr_en && st_sel && wdata[GP_BASE + NSLOT - 1 - n];
        assign gir_req[n] = wr_en && ct_sel && wdata[GR_BASE + NSLOT - 1 - n];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              ctrl_en <= '0;
        else if (wr_en && ct_sel) ctrl_en <= wdata & EN_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                rst_flag <= 1'b1;
        else if (wr_en && st_sel && wdata[RST_BIT]) rst_flag <= 1'b0;
    end

    always_comb begin
        stat_v          = '0;
        ctrl_v          = ctrl_en;
        stat_v[RST_BIT] = rst_flag;
        for (int n = 0; n < NSLOT; n++) begin
            stat_v[TE_BASE + NSLOT - 1 - n] = tx_empty[n];
            stat_v[RF_BASE + NSLOT - 1 - n] = rx_full[n];
            stat_v[GP_BASE + NSLOT - 1 - n] = gip[n];
            ctrl_v[GR_BASE + NSLOT - 1 - n] = gir_state[n];
        end
    end

    always_comb begin
        rd_next = '0;
        if (st_sel)      rd_next = stat_v;
        else if (ct_sel) rd_next = ctrl_v;
        else begin
            for (int n = 0; n < NSLOT; n++)
                if (word == WA'(RX_W + n)) rd_next = rx_data[n];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    assign irq = |(stat_v & ctrl_en);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en == '0) |-> !irq);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
    parameter int DW      = 32,
    parameter int AW      = 8,
    parameter int NSLOT   = 4,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_wr_en,
    input  logic          a_rd_en,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic [AW-1:0] b_addr,
    input  logic          b_wr_en,
    input  logic          b_rd_en,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [NSLOT-1:0] a_push, a_pop, a_ack, a_req;
    logic [NSLOT-1:0] b_push, b_pop, b_ack, b_req;
    logic [NSLOT-1:0] ab_full, ba_full, ab_ring, ba_ring;
    logic [NSLOT-1:0][DW-1:0] ab_data, ba_data;

    for (genvar n = 0; n < NSLOT; n++) begin : g_lane
        ipc_mb_slot #(.DW(DW)) u_ab_slot (
            .clk(clk), .rst_n(rst_n), .push(a_push[n]), .push_data(a_wdata),
            .pop(b_pop[n]), .data(ab_data[n]), .full(ab_full[n]));
        ipc_mb_slot #(.DW(DW)) u_ba_slot (
            .clk(clk), .rst_n(rst_n), .push(b_push[n]), .push_data(b_wdata),
            .pop(a_pop[n]), .data(ba_data[n]), .full(ba_full[n]));
        ipc_mb_bell u_ab_bell (
            .clk(clk), .rst_n(rst_n), .ring_req(a_req[n]), .ack(b_ack[n]),
            .ringing(ab_ring[n]));
        ipc_mb_bell u_ba_bell (
            .clk(clk), .rst_n(rst_n), .ring_req(b_req[n]), .ack(a_ack[n]),
            .ringing(ba_ring[n]));
    end

    ipc_mb_side #(.DW(DW), .AW(AW), .NSLOT(NSLOT), .ALT_MAP(ALT_MAP)) u_side_a (
        .clk(clk), .rst_n(rst_n), .addr(a_addr), .wr_en(a_wr_en), .rd_en(a_rd_en),
        .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq),
        .tx_push(a_push), .rx_pop(a_pop), .gip_ack(a_ack), .gir_req(a_req),
        .tx_empty(~ab_full), .rx_full(ba_full), .gip(ba_ring), .gir_state(ab_ring),
        .rx_data(ba_data));

    ipc_mb_side #(.DW(DW), .AW(AW), .NSLOT(NSLOT), .ALT_MAP(ALT_MAP)) u_side_b (
        .clk(clk), .rst_n(rst_n), .addr(b_addr), .wr_en(b_wr_en), .rd_en(b_rd_en),
        .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq),
        .tx_push(b_push), .rx_pop(b_pop), .gip_ack(b_ack), .gir_req(b_req),
        .tx_empty(~ba_full), .rx_full(ab_full), .gip(ab_ring), .gir_state(ba_ring),
        .rx_data(ab_data));
endmodule

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0]  a_addr = '0, b_addr = '0, c_addr = '0;
    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0, c_wr = 0, c_rd = 0;
    logic [31:0] a_wd = '0, b_wd = '0, c_wd = '0;
    logic [31:0] a_rdv, b_rdv, c_rdv, d_rdv;
    logic        a_irq, b_irq, c_irq, d_irq;

    int checks = 0;
    int errors = 0;

    ipc_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wr_en(a_wr), .a_rd_en(a_rd), .a_wdata(a_wd),
        .a_rdata(a_rdv), .a_irq(a_irq),
        .b_addr(b_addr), .b_wr_en(b_wr), .b_rd_en(b_rd), .b_wdata(b_wd),
        .b_rdata(b_rdv), .b_irq(b_irq));

    ipc_mailbox #(.ALT_MAP(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n),
        .a_addr(c_addr), .a_wr_en(c_wr), .a_rd_en(c_rd), .a_wdata(c_wd),
        .a_rdata(c_rdv), .a_irq(c_irq),
        .b_addr(8'h00), .b_wr_en(1'b0), .b_rd_en(1'b0), .b_wdata(32'h0),
        .b_rdata(d_rdv), .b_irq(d_irq));

    localparam logic [7:0] ST = 8'h20, CT = 8'h24;
    localparam logic [31:0] IDLE_ST = 32'h00F0_0000;

    // side, slot, data
    localparam logic [34:0] VEC [0:5] = '{
        {1'b0, 2'd0, 32'hA5A5_0001}, {1'b0, 2'd3, 32'h0000_FFFF},
        {1'b1, 2'd1, 32'h1234_5678}, {1'b1, 2'd2, 32'hDEAD_BEEF},
        {1'b0, 2'd1, 32'h8000_0000}, {1'b1, 2'd3, 32'h0F0F_0F0F}};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int side, input logic [7:0] ad, input logic [31:0] d);
        @(negedge clk);
        if (side == 0) begin a_addr = ad; a_wd = d; a_wr = 1; end
        else if (side == 1) begin b_addr = ad; b_wd = d; b_wr = 1; end
        else begin c_addr = ad; c_wd = d; c_wr = 1; end
        @(negedge clk);
        a_wr = 0; b_wr = 0; c_wr = 0;
    endtask

    task automatic rd(input int side, input logic [7:0] ad, output logic [31:0] d);
        @(negedge clk);
        if (side == 0) begin a_addr = ad; a_rd = 1; end
        else if (side == 1) begin b_addr = ad; b_rd = 1; end
        else begin c_addr = ad; c_rd = 1; end
        @(negedge clk);
        a_rd = 0; b_rd = 0; c_rd = 0;
        d = (side == 0) ? a_rdv : (side == 1) ? b_rdv : c_rdv;
    endtask

    function automatic logic [31:0] bit_at(input int base, input int slot);
        return 32'h1 << (base + 3 - slot);
    endfunction

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, ST, v); chk("R1 A status", v, 32'h00F0_0200);
        rd(1, ST, v); chk("R1 B status", v, 32'h00F0_0200);
        rd(0, CT, v); chk("R1 A control", v, 32'h0);
        chk("R1 irqs", {30'h0, a_irq, b_irq}, 32'h0);

        // R2 alternate map
        rd(2, 8'h60, v); chk("R2 alt status", v, 32'h00F0_0200);
        wr(2, 8'h64, 32'h0800_0000);
        rd(2, 8'h64, v); chk("R2 alt control", v, 32'h0800_0000);

        // R10 reset indication
        wr(0, ST, 32'h0); rd(0, ST, v); chk("R10 keep on 0", v, 32'h00F0_0200);
        wr(0, ST, 32'h200); rd(0, ST, v); chk("R10 clear on 1", v, IDLE_ST);
        wr(1, ST, 32'h200);

        // R3 R4 table
        for (int i = 0; i < 6; i++) begin
            int src, dst, s;
            logic [31:0] dat;
            src = VEC[i][34] ? 1 : 0; dst = 1 - src;
            s = int'(VEC[i][33:32]); dat = VEC[i][31:0];
            wr(src, 8'(4 * s), dat);
            rd(src, ST, v); chk("R3 writer TE", v, IDLE_ST & ~bit_at(20, s));
            rd(dst, ST, v); chk("R3 peer RF", v, IDLE_ST | bit_at(24, s));
            rd(dst, 8'(8'h10 + 4 * s), v); chk("R4 data", v, dat);
            rd(dst, ST, v); chk("R4 peer RF clr", v, IDLE_ST);
            rd(src, ST, v); chk("R4 writer TE set", v, IDLE_ST);
        end

        // R5 status read and empty read side-effect free
        rd(1, ST, v); rd(1, ST, v); chk("R5 status reread", v, IDLE_ST);
        rd(1, 8'h10, v);
        rd(1, ST, v); chk("R5 empty read B", v, IDLE_ST);
        rd(0, ST, v); chk("R5 empty read A", v, IDLE_ST);

        // R11 overwrite full slot
        wr(0, 8'h08, 32'h111); wr(0, 8'h08, 32'h222);
        rd(1, ST, v); chk("R11 still full", v, IDLE_ST | bit_at(24, 2));
        rd(1, 8'h18, v); chk("R11 latest word", v, 32'h222);

        // streaming through all slots
        for (int s = 0; s < 4; s++) wr(0, 8'(4 * s), 32'hC000_0000 + 32'(s));
        rd(1, ST, v); chk("R3 all full", v, 32'h0FF0_0000);
        rd(0, ST, v); chk("R3 all busy", v, 32'h0);
        for (int s = 0; s < 4; s++) begin
            rd(1, 8'(8'h10 + 4 * s), v); chk("R4 stream", v, 32'hC000_0000 + 32'(s));
        end
        rd(0, ST, v); chk("R4 all free", v, IDLE_ST);

        // R8 control storage
        wr(0, CT, 32'hFFF0_01FF);
        rd(0, CT, v); chk("R8 readback", v, 32'hFFF0_0000);
        chk("R9 TE irq", {31'h0, a_irq}, 32'h1);
        wr(0, CT, bit_at(24, 0));
        chk("R9 masked", {31'h0, a_irq}, 32'h0);
        wr(1, 8'h00, 32'h77);
        chk("R9 RF irq", {31'h0, a_irq}, 32'h1);
        rd(0, 8'h10, v); chk("R4 B to A", v, 32'h77);
        chk("R9 irq drop", {31'h0, a_irq}, 32'h0);
        wr(0, CT, 32'h0);

        // R6 R7 doorbell 3
        wr(1, CT, bit_at(28, 3));
        wr(0, CT, bit_at(16, 3));
        rd(1, ST, v); chk("R6 peer pending", v, IDLE_ST | bit_at(28, 3));
        rd(0, CT, v); chk("R6 request visible", v, bit_at(16, 3));
        chk("R9 bell irq", {31'h0, b_irq}, 32'h1);
        wr(1, ST, 32'h0);
        rd(1, ST, v); chk("R7 zero keeps", v, IDLE_ST | bit_at(28, 3));
        wr(1, ST, bit_at(28, 3));
        rd(1, ST, v); chk("R7 cleared", v, IDLE_ST);
        rd(0, CT, v); chk("R7 request released", v, 32'h0);
        chk("R9 bell irq off", {31'h0, b_irq}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule